// File: doc/BRIEF.md
# OFDM Frame Resource Mapper

This block sequences one OFDM transmit frame, one frequency bin at a time. A frame has 36 symbols of 128 bins each. For every bin the block presents the symbol number, the bin number, a 3-bit code naming what the bin carries, and an element index. The code is one of guard, DC null, synchronization, reference, header, pilot or data. The element index tells the source of that resource which element of its sequence to supply.

The sequencer sits idle until a one-cycle frame-start pulse arrives. It then offers bins to a downstream consumer under a valid/ready handshake and moves to the next bin only when both are high. It raises a frame-end flag on the final bin and returns to idle after that bin is accepted.

The symbol schedule is fixed and always in the same order:
- symbol 0 carries synchronization;
- symbols 1 and 2 carry reference signals;
- symbol 3 carries the header;
- symbols 4 to 35 carry payload with interleaved pilots.

Top module: `ofdm_res_mapper`

## Requirements
- R1: After reset `map_valid` and `frame_last` are 0. A `frame_go` pulse while idle makes `map_valid` 1 on the next cycle, with symbol 0 and bin 0 presented.
- R2: While `map_valid` is 1 and `map_ready` is 0, all outputs keep their values.
- R3: Each accepted bin (valid and ready both 1) advances the bin number by one. After bin 127 the bin number returns to 0 and the symbol number increments. `map_valid` stays 1 from the first bin to the last, so a frame has exactly 36 x 128 accepted bins.
- R4: In every symbol, bins 0..27 and bins 101..127 have type code 0 (guard), and bin 64 has type code 1 (DC null). All of these bins report element index 0.
- R5: The active bins are 28..63 and 65..100. Their position is k = bin-28 below the DC bin and k = bin-29 above it. In symbol 0 the type is 2 (sync), in symbols 1 and 2 it is 3 (reference), and in symbol 3 it is 4 (header). In all three cases the element index equals k.
- R6: In symbols 4..35, an active bin whose position k is a multiple of 6 has type 5 (pilot) with index k/6, giving 0..11 per symbol. Every other active bin has type 6 (data), with an index that counts 0..59 within the symbol. Each data symbol holds 12 pilots and 60 data bins.
- R7: `frame_last` is 1 exactly while symbol 35, bin 127 is presented. After that bin is accepted, `map_valid` is 0 and stays 0 until the next `frame_go`.
- R8: A `frame_go` pulse during a frame has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_go | input | 1 | Frame-start pulse |
| map_ready | input | 1 | Consumer accepts the presented bin |
| map_valid | output | 1 | A bin descriptor is presented |
| sym_num | output | 6 | Symbol number 0..35 |
| bin_num | output | 7 | Bin number 0..127 |
| res_type | output | 3 | Resource type code |
| elem_idx | output | 7 | Element index into the sequence of that type |
| frame_last | output | 1 | Final bin of the frame is presented |

## Verification
The assertions assume the following about the inputs:
- `map_ready` may toggle freely on any cycle.
- `frame_go` may arrive at any time, including in the middle of a frame.
- reset is held low for at least one clock edge before the first check.

The stimulus works within these assumptions. It holds reset for several cycles, then runs frames with the consumer always ready and with a pseudo-random ready pattern. It also pulses the start input in the middle of a frame while ready is low, so that a stray start coincides with back-pressure.

// File: rtl/ofdm_map_pkg.sv
package ofdm_map_pkg;

  typedef enum logic [2:0] {
    RK_GUARD = 3'd0,
    RK_DC    = 3'd1,
    RK_SYNC  = 3'd2,
    RK_REF   = 3'd3,
    RK_HDR   = 3'd4,
    RK_PILOT = 3'd5,
    RK_DATA  = 3'd6
  } res_kind_t;

  // Position of an active bin among the active bins, skipping the DC bin.
  function automatic int act_pos(input int bin, input int left_g, input int n_act);
    int half;
    half = n_act / 2;
    if (bin < left_g + half) return bin - left_g;
    return bin - left_g - 1;
  endfunction

  function automatic bit pos_is_pilot(input int k, input int spacing);
    return (k % spacing) == 0;
  endfunction

  function automatic int pilot_slot(input int k, input int spacing);
    return k / spacing;
  endfunction

  // Data bins seen before position k (pilot at k=0, k=spacing, ...).
  function automatic int data_slot(input int k, input int spacing);
    return k - (k / spacing) - 1;
  endfunction

endpackage

// File: rtl/ofdm_frame_walker.sv
module ofdm_frame_walker #(
  parameter int N_SYM = 36,
  parameter int N_BIN = 128,
  parameter int SYM_W = $clog2(N_SYM),
  parameter int BIN_W = $clog2(N_BIN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  output logic             busy_o,
  output logic [SYM_W-1:0] sym_o,
  output logic [BIN_W-1:0] bin_o,
  output logic             adv_o,
  output logic             last_o
);
  localparam logic [SYM_W-1:0] SYM_LAST = SYM_W'(N_SYM - 1);
  localparam logic [BIN_W-1:0] BIN_LAST = BIN_W'(N_BIN - 1);

  logic             busy_q;
  logic [SYM_W-1:0] sym_q;
  logic [BIN_W-1:0] bin_q;
  logic             bin_wrap;
  logic             launch;

  assign bin_wrap = (bin_q == BIN_LAST);
  assign last_o   = busy_q && bin_wrap && (sym_q == SYM_LAST);
  assign adv_o    = busy_q && ready_i;
  assign launch   = start_i && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sym_q  <= '0;
      bin_q  <= '0;
    end else if (launch) begin
      busy_q <= 1'b1;
      sym_q  <= '0;
      bin_q  <= '0;
    end else if (adv_o) begin
      if (last_o) begin
        busy_q <= 1'b0;
      end else if (bin_wrap) begin
        bin_q <= '0;
        sym_q <= sym_q + SYM_W'(1);
      end else begin
        bin_q <= bin_q + BIN_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign sym_o  = sym_q;
  assign bin_o  = bin_q;

  a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !ready_i |=> busy_q && $stable(sym_q) && $stable(bin_q));

  a_r3_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o && !bin_wrap |=> bin_q == $past(bin_q) + BIN_W'(1) && sym_q == $past(sym_q));

  a_r3_sym_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o && bin_wrap && !last_o |=> bin_q == '0 && sym_q == $past(sym_q) + SYM_W'(1));

  a_r7_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    adv_o && last_o |=> !busy_q);

  a_r8_start_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && start_i && !ready_i |=> busy_q && $stable(sym_q) && $stable(bin_q));

endmodule

// File: rtl/ofdm_bin_class.sv
module ofdm_bin_class #(
  parameter int N_BIN  = 128,
  parameter int LEFT_G = 28,
  parameter int N_ACT  = 72,
  parameter int BIN_W  = $clog2(N_BIN),
  parameter int IDX_W  = $clog2(N_ACT)
) (
  input  logic [BIN_W-1:0] bin_i,
  output logic             guard_o,
  output logic             dc_o,
  output logic [IDX_W-1:0] kpos_o
);
  import ofdm_map_pkg::*;

  localparam int HALF = N_ACT / 2;
  localparam logic [BIN_W-1:0] FIRST_ACT  = BIN_W'(LEFT_G);
  localparam logic [BIN_W-1:0] DC_BIN     = BIN_W'(LEFT_G + HALF);
  localparam logic [BIN_W-1:0] RIGHT_GRD  = BIN_W'(LEFT_G + N_ACT + 1);

  assign guard_o = (bin_i < FIRST_ACT) || (bin_i >= RIGHT_GRD);
  assign dc_o    = (bin_i == DC_BIN);
  assign kpos_o  = IDX_W'(act_pos(int'(bin_i), LEFT_G, N_ACT));

endmodule

// File: rtl/ofdm_sym_sched.sv
module ofdm_sym_sched #(
  parameter int N_REF = 2,
  parameter int SYM_W = 6
) (
  input  logic [SYM_W-1:0]            sym_i,
  output ofdm_map_pkg::res_kind_t     kind_o
);
  import ofdm_map_pkg::*;

  localparam logic [SYM_W-1:0] HDR_SYM = SYM_W'(N_REF + 1);

  always_comb begin
    if (sym_i == '0)          kind_o = RK_SYNC;
    else if (sym_i < HDR_SYM) kind_o = RK_REF;
    else if (sym_i == HDR_SYM) kind_o = RK_HDR;
    else                      kind_o = RK_DATA;
  end

endmodule

// File: rtl/ofdm_res_mapper.sv
module ofdm_res_mapper #(
  parameter int N_SYM  = 36,
  parameter int N_BIN  = 128,
  parameter int LEFT_G = 28,
  parameter int N_ACT  = 72,
  parameter int N_REF  = 2,
  parameter int PIL_SP = 6,
  parameter int SYM_W  = $clog2(N_SYM),
  parameter int BIN_W  = $clog2(N_BIN),
  parameter int IDX_W  = $clog2(N_ACT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_go,
  input  logic             map_ready,
  output logic             map_valid,
  output logic [SYM_W-1:0] sym_num,
  output logic [BIN_W-1:0] bin_num,
  output logic [2:0]       res_type,
  output logic [IDX_W-1:0] elem_idx,
  output logic             frame_last
);
  import ofdm_map_pkg::*;

  localparam int N_PIL  = N_ACT / PIL_SP;
  localparam int N_DATA = N_ACT - N_PIL;

  logic             busy, adv, last;
  logic [SYM_W-1:0] sym;
  logic [BIN_W-1:0] bin;
  logic             is_guard, is_dc;
  logic [IDX_W-1:0] kpos;
  res_kind_t        sym_kind;
  res_kind_t        kind;
  logic [IDX_W-1:0] idx;

  ofdm_frame_walker #(.N_SYM(N_SYM), .N_BIN(N_BIN), .SYM_W(SYM_W), .BIN_W(BIN_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_i(frame_go), .ready_i(map_ready),
    .busy_o(busy), .sym_o(sym), .bin_o(bin), .adv_o(adv), .last_o(last)
  );

  ofdm_bin_class #(.N_BIN(N_BIN), .LEFT_G(LEFT_G), .N_ACT(N_ACT),
                   .BIN_W(BIN_W), .IDX_W(IDX_W)) u_class (
    .bin_i(bin), .guard_o(is_guard), .dc_o(is_dc), .kpos_o(kpos)
  );

  ofdm_sym_sched #(.N_REF(N_REF), .SYM_W(SYM_W)) u_sched (
    .sym_i(sym), .kind_o(sym_kind)
  );

  always_comb begin
    kind = RK_GUARD;
    idx  = '0;
    if (is_guard) begin
      kind = RK_GUARD;
    end else if (is_dc) begin
      kind = RK_DC;
    end else if (sym_kind != RK_DATA) begin
      kind = sym_kind;
      idx  = kpos;
    end else if (pos_is_pilot(int'(kpos), PIL_SP)) begin
      kind = RK_PILOT;
      idx  = IDX_W'(pilot_slot(int'(kpos), PIL_SP));
    end else begin
      kind = RK_DATA;
      idx  = IDX_W'(data_slot(int'(kpos), PIL_SP));
    end
  end

  assign map_valid  = busy;
  assign sym_num    = sym;
  assign bin_num    = bin;
  assign res_type   = kind;
  assign elem_idx   = idx;
  assign frame_last = last;

  a_r6_data_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid && kind == RK_DATA |-> int'(idx) < N_DATA);

  a_r6_pilot_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid && kind == RK_PILOT |-> int'(idx) < N_PIL);

  a_r6_pilot_only_in_data_sym: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid && kind == RK_PILOT |-> int'(sym) > N_REF + 1);

  a_r4_dc_mid_bin: assert property (@(posedge clk) disable iff (!rst_n)
    map_valid && kind == RK_DC |-> int'(bin) == LEFT_G + N_ACT / 2 && idx == '0);

  a_r7_last_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last && map_ready |=> !map_valid);

  a_r1_idle_no_last: assert property (@(posedge clk) disable iff (!rst_n)
    !map_valid |-> !frame_last);

endmodule

// File: tb/test_ofdm_res_mapper.sv
module test_ofdm_res_mapper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_go = 1'b0;
  logic       map_ready = 1'b0;
  logic       map_valid;
  logic [5:0] sym_num;
  logic [6:0] bin_num;
  logic [2:0] res_type;
  logic [6:0] elem_idx;
  logic       frame_last;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ofdm_res_mapper i_ofdm_res_mapper (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .map_ready(map_ready),
    .map_valid(map_valid), .sym_num(sym_num), .bin_num(bin_num),
    .res_type(res_type), .elem_idx(elem_idx), .frame_last(frame_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(map_valid == 1'b0, "R1 valid in reset", map_valid, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(map_valid == 1'b0, "R1 valid idle", map_valid, 0);
    chk(frame_last == 1'b0, "R1 last idle", frame_last, 0);
  endtask

  task automatic pulse_start();
    frame_go = 1'b1;
    @(negedge clk);
    frame_go = 1'b0;
    chk(map_valid == 1'b1, "R1 valid after start", map_valid, 1);
    chk(sym_num == 0 && bin_num == 0, "R1 first position",
        int'(sym_num) * 128 + int'(bin_num), 0);
  endtask

  // mode 0: always ready; 1: pseudo-random ready; 2: random ready plus stray start
  task automatic t_frame(input int mode);
    int s = 0, b = 0, act = 0, pil = 0, dat = 0;
    int npil = 0, ndat = 0;
    int et, ei;
    bit done = 1'b0;
    bit poked = 1'b0;
    logic [7:0] lf = 8'hA5;
    bit rdy;
    pulse_start();
    while (!done) begin
      if (b < 28 || b > 100) begin et = 0; ei = 0; end
      else if (b == 64) begin et = 1; ei = 0; end
      else if (s == 0) begin et = 2; ei = act; end
      else if (s < 3) begin et = 3; ei = act; end
      else if (s == 3) begin et = 4; ei = act; end
      else if (act % 6 == 0) begin et = 5; ei = pil; end
      else begin et = 6; ei = dat; end

      chk(map_valid == 1'b1, "R3 valid through frame", map_valid, 1);
      chk(int'(sym_num) == s && int'(bin_num) == b, "R3 position",
          int'(sym_num) * 128 + int'(bin_num), s * 128 + b);
      if (et <= 1)
        chk(int'(res_type) == et && int'(elem_idx) == ei, "R4 guard/dc",
            int'(res_type) * 1000 + int'(elem_idx), et * 1000 + ei);
      else if (et <= 4)
        chk(int'(res_type) == et && int'(elem_idx) == ei, "R5 preamble",
            int'(res_type) * 1000 + int'(elem_idx), et * 1000 + ei);
      else
        chk(int'(res_type) == et && int'(elem_idx) == ei, "R6 pilot/data",
            int'(res_type) * 1000 + int'(elem_idx), et * 1000 + ei);
      chk(frame_last == (s == 35 && b == 127), "R7 last flag",
          frame_last, (s == 35 && b == 127));

      if (mode == 0) rdy = 1'b1;
      else begin
        lf  = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        rdy = lf[0] | lf[3];
      end
      frame_go = 1'b0;
      if (mode == 2 && !poked && s == 10 && b == 50) begin
        rdy = 1'b0;
        frame_go = 1'b1;
        poked = 1'b1;
      end
      map_ready = rdy;
      @(negedge clk);
      if (frame_go) begin
        frame_go = 1'b0;
        chk(map_valid == 1'b1 && int'(sym_num) == 10 && int'(bin_num) == 50,
            "R8 stray start", int'(sym_num) * 128 + int'(bin_num), 10 * 128 + 50);
      end
      if (!rdy) begin
        chk(int'(sym_num) == s && int'(bin_num) == b, "R2 hold",
            int'(sym_num) * 128 + int'(bin_num), s * 128 + b);
      end else begin
        if (et >= 2) act++;
        if (et == 5) begin pil++; npil++; end
        if (et == 6) begin dat++; ndat++; end
        if (s == 35 && b == 127) done = 1'b1;
        else if (b == 127) begin b = 0; s++; act = 0; pil = 0; dat = 0; end
        else b++;
      end
    end
    map_ready = 1'b0;
    chk(npil == 12 * 32 && ndat == 60 * 32, "R6 counts per frame",
        npil * 10000 + ndat, 384 * 10000 + 1920);
    chk(map_valid == 1'b0, "R7 idle after end", map_valid, 0);
    map_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk(map_valid == 1'b0 && frame_last == 1'b0, "R7 waits for start", map_valid, 0);
    map_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_frame(0);
    t_frame(1);
    t_frame(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule